// File: doc/BRIEF.md
# MDIO Management Slave Emulator

This block plays the PHY end of a two-wire management link whose wires a host toggles through a small control register. That register holds four bits: bit 0 is the data-out bit driven by the host, bit 1 is the data-in bit returned to the host, bit 2 is the output enable and bit 3 is the management clock. Each host write that moves the clock bit from 0 to 1 is one bit time. On that bit time the block shifts one bit into a 32-bit window. It resynchronises whenever that window holds 32 ones. It decodes the 16-bit frame header that follows. It then either serves a read out of a 32-entry table of 16-bit PHY registers or accepts a write.

The host reads the control register back to collect read data on the data-in bit, one bit per rising clock. Accepted writes are reported on a one-cycle commit strobe with the PHY address, register address and data. They are then dropped, so the table keeps its reset contents. After the last bit of a frame the bit counter parks at a floor value. Further clocking without a new preamble never decodes another header.

Top module: `mgmt_phy_slave`

## Requirements
- R1: After reset the control register reads back 0 and the commit strobe is low.
- R2: Bit 1 of the control register (data-in) is read-only: host writes never change it, and it changes only on a bit time.
- R3: A bit time is a host write that sets bit 3 while the stored bit 3 is 0. Writes that leave bit 3 high or low shift nothing and advance nothing.
- R4: The bit shifted in on a bit time is 1 only when both bit 0 and bit 2 of the written value are 1, and 0 otherwise.
- R5: A window of 32 consecutive ones loads the bit counter with 32. A run of 31 ones followed by a header decodes nothing.
- R6: The 16 bits after the preamble form the header, sent first bit first: start (2 bits), opcode (2), PHY address (5), register address (5), turnaround (2). Start 01, opcode 01 and turnaround 10 make a write. Its next 16 bits are reported once on the commit strobe, together with the PHY and register addresses.
- R7: Start 01, opcode 10 and a turnaround whose last bit is 0 make a read. The addressed table entry appears on data-in over the next 16 bit times, most significant bit first. Register 2 reads 0x0022, register 3 reads 0x161a and every other register reads 0.
- R8: Any other header returns the block to idle: no commit, and data-in stays 0 over the following 16 bit times.
- R9: Committed writes do not alter the table; later reads return the reset values.
- R10: Once a frame has ended, any number of bit times without a new 32-ones preamble decodes no header and commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Host write strobe for the control register |
| ctl_wdata | input | 4 | Value written by the host (bit0 data-out, bit2 enable, bit3 clock) |
| ctl_rdata | output | 4 | Control register read-back, bit1 carries data-in |
| wr_commit | output | 1 | One-cycle pulse when a write frame completes |
| wr_phy | output | 5 | PHY address of the committed write |
| wr_reg | output | 5 | Register address of the committed write |
| wr_data | output | 16 | Data of the committed write |

## Verification
The bench builds the block with its default values: 16-bit data, a 32-entry table and identifier values 0x0022 and 0x161a. With only 32 addresses, every table entry can be read back in one sweep. Every class of malformed header (start, opcode and turnaround variants) is covered, along with preamble runs of 31, 32 and 40 ones. The small table also leaves room for a long stretch of clocking without a preamble after each frame, so a counter that wraps would decode a stray header inside the run.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  // control register bit positions
  localparam int CB_DO  = 0;
  localparam int CB_DI  = 1;
  localparam int CB_OE  = 2;
  localparam int CB_CLK = 3;
  localparam int CTL_W  = 4;

  // header layout (16 bits, first bit on the wire at the top)
  localparam int HDR_W    = 16;
  localparam int REG_AW   = 5;
  localparam int PHY_LSB  = 7;
  localparam int REGA_LSB = 2;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} mst_t;

  function automatic mst_t hdr_decode(input logic [HDR_W-1:0] h);
    logic [1:0] st, op, ta;
    st = h[15:14];
    op = h[13:12];
    ta = h[1:0];
    if (st == START_CODE && op == OP_WRITE && ta == TA_WRITE) return ST_WR;
    if (st == START_CODE && op == OP_READ && !ta[0]) return ST_RD;
    return ST_IDLE;
  endfunction
endpackage

// File: rtl/mgmt_edge_shift.sv
module mgmt_edge_shift #(
  parameter int SHIFT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               clk_bit,
  input  logic               do_bit,
  input  logic               oe_bit,
  input  logic               last_clk,
  output logic               rise,
  output logic [SHIFT_W-1:0] shift_next,
  output logic               sync_hit
);
  // only SHIFT_W-1 bits are stored; the new bit completes the window
  logic [SHIFT_W-2:0] shift_q;
  logic               in_bit;

  assign rise       = ctl_we && clk_bit && !last_clk;
  assign in_bit     = do_bit & oe_bit;
  assign shift_next = {shift_q, in_bit};
  assign sync_hit   = &shift_next;

  always_ff @(posedge clk) begin
    if (!rst_n)    shift_q <= '0;
    else if (rise) shift_q <= shift_next[SHIFT_W-2:0];
  end

  // R3: the window moves only on a bit time
  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(shift_q));
endmodule

// File: rtl/mgmt_phy_table.sv
module mgmt_phy_table #(
  parameter int                NREG   = 32,
  parameter int                DATA_W = 16,
  parameter int                AW     = 5,
  parameter int                IDX_A  = 2,
  parameter logic [DATA_W-1:0] VAL_A  = 16'h0022,
  parameter int                IDX_B  = 3,
  parameter logic [DATA_W-1:0] VAL_B  = 16'h161a
) (
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] entry [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    if (i == IDX_A)      begin : g_a assign entry[i] = VAL_A; end
    else if (i == IDX_B) begin : g_b assign entry[i] = VAL_B; end
    else                 begin : g_z assign entry[i] = '0;    end
  end

  assign rdata = (int'(addr) < NREG) ? entry[addr] : '0;
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
  import mgmt_pkg::*;
#(
  parameter int SHIFT_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise,
  input  logic                 sync_hit,
  input  logic [HDR_W-1:0]     hdr_bits,
  input  logic [DATA_W-1:0]    tbl_data,
  output logic [REG_AW-1:0]    tbl_addr,
  output logic                 di,
  output logic                 wr_commit,
  output logic [REG_AW-1:0]    wr_phy,
  output logic [REG_AW-1:0]    wr_reg,
  output logic [DATA_W-1:0]    wr_data
);
  localparam int CW = $clog2(SHIFT_W) + 2;
  localparam logic signed [CW-1:0] CNT_LOAD  = CW'(SHIFT_W);
  localparam logic signed [CW-1:0] CNT_HDR   = CW'(DATA_W);
  localparam logic signed [CW-1:0] CNT_ZERO  = '0;
  localparam logic signed [CW-1:0] CNT_FLOOR = '1;

  logic signed [CW-1:0] cnt_q, cnt_a;
  mst_t                 st_q, hdr_st, st_mid;
  logic [DATA_W-1:0]    dout_q;
  logic [REG_AW-1:0]    phy_q, reg_q;
  logic                 at_hdr, drive_bit, finish;

  assign tbl_addr  = hdr_bits[REGA_LSB +: REG_AW];
  assign cnt_a     = sync_hit ? CNT_LOAD : cnt_q;
  assign at_hdr    = rise && (cnt_a == CNT_HDR);
  assign hdr_st    = hdr_decode(hdr_bits);
  assign st_mid    = at_hdr ? hdr_st : st_q;
  assign drive_bit = rise && (cnt_a < CNT_HDR) && (cnt_a >= CNT_ZERO) && (st_mid == ST_RD);
  assign finish    = rise && (cnt_a == CNT_ZERO) && (st_mid != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= CNT_FLOOR;
      st_q      <= ST_IDLE;
      dout_q    <= '0;
      phy_q     <= '0;
      reg_q     <= '0;
      di        <= 1'b0;
      wr_commit <= 1'b0;
      wr_phy    <= '0;
      wr_reg    <= '0;
      wr_data   <= '0;
    end else begin
      wr_commit <= 1'b0;
      if (rise) begin
        // counter parks at the floor instead of wrapping
        cnt_q <= (cnt_a > CNT_FLOOR) ? cnt_a - 1'b1 : CNT_FLOOR;
        st_q  <= finish ? ST_IDLE : st_mid;
        if (at_hdr && hdr_st != ST_IDLE) begin
          phy_q <= hdr_bits[PHY_LSB +: REG_AW];
          reg_q <= tbl_addr;
        end
        if (at_hdr && hdr_st == ST_RD) begin
          dout_q <= tbl_data;
        end else if (drive_bit) begin
          di     <= dout_q[DATA_W-1];
          dout_q <= dout_q << 1;
        end
        if (finish && st_mid == ST_WR) begin
          wr_commit <= 1'b1;
          wr_phy    <= phy_q;
          wr_reg    <= reg_q;
          wr_data   <= hdr_bits[DATA_W-1:0];
        end
      end
    end
  end

  // R10: the counter never runs below its floor
  assert_cnt_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= CNT_FLOOR);
  // R6: a commit is a single-cycle pulse
  assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
  // R6: a commit only ends a frame that decoded as a write
  assert_commit_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_commit) |-> $past(st_q) == ST_WR);
  // R8: an idle frame never drives data-in
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mid == ST_IDLE && rise) |=> $stable(di));
endmodule

// File: rtl/mgmt_phy_slave.sv
module mgmt_phy_slave
  import mgmt_pkg::*;
#(
  parameter int                NREG      = 32,
  parameter int                DATA_W    = 16,
  parameter int                ID_HI_IDX = 2,
  parameter logic [DATA_W-1:0] ID_HI     = 16'h0022,
  parameter int                ID_LO_IDX = 3,
  parameter logic [DATA_W-1:0] ID_LO     = 16'h161a
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  output logic [3:0]        ctl_rdata,
  output logic              wr_commit,
  output logic [4:0]        wr_phy,
  output logic [4:0]        wr_reg,
  output logic [15:0]       wr_data
);
  localparam int SHIFT_W = 2 * DATA_W;

  logic                 clk_q, oe_q, do_q, di;
  logic                 rise, sync_hit;
  logic [SHIFT_W-1:0]   shift_next;
  logic [REG_AW-1:0]    tbl_addr;
  logic [DATA_W-1:0]    tbl_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      oe_q  <= 1'b0;
      do_q  <= 1'b0;
    end else if (ctl_we) begin
      clk_q <= ctl_wdata[CB_CLK];
      oe_q  <= ctl_wdata[CB_OE];
      do_q  <= ctl_wdata[CB_DO];
    end
  end

  always_comb begin
    ctl_rdata         = '0;
    ctl_rdata[CB_DO]  = do_q;
    ctl_rdata[CB_DI]  = di;
    ctl_rdata[CB_OE]  = oe_q;
    ctl_rdata[CB_CLK] = clk_q;
  end

  mgmt_edge_shift #(.SHIFT_W(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we),
    .clk_bit(ctl_wdata[CB_CLK]), .do_bit(ctl_wdata[CB_DO]), .oe_bit(ctl_wdata[CB_OE]),
    .last_clk(clk_q), .rise(rise), .shift_next(shift_next), .sync_hit(sync_hit)
  );

  mgmt_phy_table #(
    .NREG(NREG), .DATA_W(DATA_W), .AW(REG_AW),
    .IDX_A(ID_HI_IDX), .VAL_A(ID_HI), .IDX_B(ID_LO_IDX), .VAL_B(ID_LO)
  ) u_table (
    .addr(tbl_addr), .rdata(tbl_data)
  );

  mgmt_frame_fsm #(.SHIFT_W(SHIFT_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .sync_hit(sync_hit),
    .hdr_bits(shift_next[HDR_W-1:0]), .tbl_data(tbl_data), .tbl_addr(tbl_addr),
    .di(di), .wr_commit(wr_commit), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  // R2: data-in moves only on a bit time, never on a plain host write
  assert_di_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(ctl_rdata[CB_DI]));
endmodule

// File: tb/mgmt_phy_slave_tb.sv
module mgmt_phy_slave_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_wdata = 4'h0;
  logic [3:0]  ctl_rdata;
  logic        wr_commit;
  logic [4:0]  wr_phy, wr_reg;
  logic [15:0] wr_data;

  mgmt_phy_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .wr_commit(wr_commit), .wr_phy(wr_phy),
    .wr_reg(wr_reg), .wr_data(wr_data)
  );

  int total = 0;
  int bad = 0;
  int ncommit = 0;
  logic [4:0]  c_phy = '0, c_reg = '0;
  logic [15:0] c_data = '0;

  always @(negedge clk) begin
    if (rst_n && wr_commit) begin
      ncommit = ncommit + 1;
      c_phy   = wr_phy;
      c_reg   = wr_reg;
      c_data  = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(input int r);
    if (r == 2) return 16'h0022;
    if (r == 3) return 16'h161a;
    return 16'h0000;
  endfunction

  function automatic logic [31:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [1:0] ta, input logic [15:0] d);
    return {st, op, phy, ra, ta, d};
  endfunction

  task automatic host_wr(input logic [3:0] v);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // one bit time; dup adds a write that keeps the clock high and sets bit 1
  task automatic tick(input logic b, input logic oe, input bit dup, output logic di);
    host_wr({1'b0, oe, 1'b0, b});
    host_wr({1'b1, oe, 1'b0, b});
    if (dup) host_wr({1'b1, oe, 1'b1, b});
    di = ctl_rdata[1];
  endtask

  task automatic xfer(input int nones, input logic [31:0] f, input logic oe_ta,
                      input logic oe_dat, input bit dup, output logic [15:0] rd);
    logic d;
    logic oe;
    rd = '0;
    for (int i = 0; i < 2; i++) tick(1'b0, 1'b1, 1'b0, d);
    for (int i = 0; i < nones; i++) tick(1'b1, 1'b1, 1'b0, d);
    for (int i = 31; i >= 0; i--) begin
      oe = (i >= 18) ? 1'b1 : (i >= 16) ? oe_ta : oe_dat;
      tick(f[i], oe, dup && (i < 16), d);
      if (i < 16) rd = {rd[14:0], d};
    end
    tick(1'b0, 1'b1, 1'b0, d);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int n0;
    logic [4:0] phy, ra;
    logic [15:0] dv;
    logic [15:0] pat;
    logic d;

    repeat (3) @(negedge clk);
    chk(ctl_rdata == 4'h0, "R1 ctl reset", 32'(ctl_rdata), 0);
    chk(wr_commit == 1'b0, "R1 commit reset", 32'(wr_commit), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: setting bit 1 from the host has no effect
    host_wr(4'b0010);
    chk(ctl_rdata == 4'b0000, "R2 di read-only", 32'(ctl_rdata), 0);

    // R7: sweep every table entry
    for (int r = 0; r < 32; r++) begin
      xfer(32, mkf(2'b01, 2'b10, 5'd1, 5'(r), 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
      chk(rd == exp_reg(r), $sformatf("R7 read reg %0d", r), 32'(rd), 32'(exp_reg(r)));
    end

    // R6: accepted writes with distinct fields
    for (int k = 0; k < 4; k++) begin
      phy = 5'(k * 7 + 1);
      ra  = (k == 0) ? 5'd3 : (k == 1) ? 5'd2 : 5'(k * 9);
      dv  = 16'hA5C3 ^ 16'(k * 16'h1111);
      n0  = ncommit;
      xfer(32, mkf(2'b01, 2'b01, phy, ra, 2'b10, dv), 1'b1, 1'b1, 1'b0, rd);
      chk(ncommit == n0 + 1, "R6 commit count", 32'(ncommit - n0), 1);
      chk(c_phy == phy, "R6 phy field", 32'(c_phy), 32'(phy));
      chk(c_reg == ra, "R6 reg field", 32'(c_reg), 32'(ra));
      chk(c_data == dv, "R6 data field", 32'(c_data), 32'(dv));
    end

    // R9: table keeps reset values after writes
    xfer(32, mkf(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
    chk(rd == 16'h161a, "R9 reg 3 after write", 32'(rd), 32'h161a);
    xfer(32, mkf(2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
    chk(rd == 16'h0022, "R9 reg 2 after write", 32'(rd), 32'h0022);
    xfer(32, mkf(2'b01, 2'b10, 5'd0, 5'd18, 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
    chk(rd == 16'h0000, "R9 reg 18 after write", 32'(rd), 0);

    // R8: malformed write headers
    n0 = ncommit;
    xfer(32, mkf(2'b01, 2'b00, 5'd1, 5'd4, 2'b10, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    xfer(32, mkf(2'b01, 2'b11, 5'd1, 5'd4, 2'b10, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    xfer(32, mkf(2'b00, 2'b01, 5'd1, 5'd4, 2'b10, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    xfer(32, mkf(2'b11, 2'b01, 5'd1, 5'd4, 2'b10, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    xfer(32, mkf(2'b01, 2'b01, 5'd1, 5'd4, 2'b11, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    xfer(32, mkf(2'b01, 2'b01, 5'd1, 5'd4, 2'b00, 16'h1234), 1'b1, 1'b1, 1'b0, rd);
    chk(ncommit == n0, "R8 bad write headers", 32'(ncommit - n0), 0);
    // R8: read with turnaround low bit set returns nothing
    xfer(32, mkf(2'b01, 2'b10, 5'd1, 5'd3, 2'b01, 16'h0), 1'b1, 1'b0, 1'b0, rd);
    chk(rd == 16'h0000, "R8 bad read turnaround", 32'(rd), 0);
    xfer(32, mkf(2'b00, 2'b10, 5'd1, 5'd3, 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
    chk(rd == 16'h0000, "R8 bad read start", 32'(rd), 0);

    // R4: data-out without enable shifts zeros
    xfer(32, mkf(2'b01, 2'b01, 5'd9, 5'd7, 2'b10, 16'hFFFF), 1'b1, 1'b0, 1'b0, rd);
    chk(c_data == 16'h0000, "R4 gated data", 32'(c_data), 0);
    xfer(32, mkf(2'b01, 2'b01, 5'd9, 5'd7, 2'b10, 16'hFFFF), 1'b1, 1'b1, 1'b0, rd);
    chk(c_data == 16'hFFFF, "R4 enabled data", 32'(c_data), 32'hFFFF);

    // R5: preamble length
    n0 = ncommit;
    xfer(31, mkf(2'b01, 2'b01, 5'd2, 5'd5, 2'b10, 16'h5A5A), 1'b1, 1'b1, 1'b0, rd);
    chk(ncommit == n0, "R5 short preamble", 32'(ncommit - n0), 0);
    xfer(40, mkf(2'b01, 2'b01, 5'd2, 5'd5, 2'b10, 16'h5A5A), 1'b1, 1'b1, 1'b0, rd);
    chk(ncommit == n0 + 1 && c_data == 16'h5A5A, "R5 long preamble", 32'(c_data), 32'h5A5A);
    xfer(31, mkf(2'b01, 2'b10, 5'd2, 5'd3, 2'b00, 16'h0), 1'b0, 1'b0, 1'b0, rd);
    chk(rd == 16'h0000, "R5 short preamble read", 32'(rd), 0);

    // R3: extra writes with clock held high do not advance the read
    xfer(32, mkf(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'h0), 1'b0, 1'b0, 1'b1, rd);
    chk(rd == 16'h161a, "R3 clock held high", 32'(rd), 32'h161a);

    // R10: long clocking without preamble, repeating a write header
    n0  = ncommit;
    pat = mkf(2'b01, 2'b01, 5'd0, 5'd3, 2'b10, 16'h0)[31:16];
    for (int i = 0; i < 320; i++) tick(pat[15 - (i % 16)], 1'b1, 1'b0, d);
    chk(ncommit == n0, "R10 no retrigger", 32'(ncommit - n0), 0);
    xfer(32, mkf(2'b01, 2'b01, 5'd3, 5'd1, 2'b10, 16'hC0DE), 1'b1, 1'b1, 1'b0, rd);
    chk(ncommit == n0 + 1 && c_data == 16'hC0DE, "R10 resync after idle", 32'(c_data), 32'hC0DE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule